// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block keeps a decoder supplied with instruction bytes. It holds two whole 16-byte line buffers and fills them from a memory port one line at a time, in program order. Filling does not wait on the decoder, so both buffers stay full whenever memory keeps up. The decoder sees an 8-byte window that starts at the current read point, together with a count of how many of those bytes are valid. Each cycle it reports how many bytes it took, anywhere from 0 to 8. A window or a consume may cross from the end of one buffer into the start of the other.

When a buffer has been fully consumed it is released at once, and the next sequential line is requested into it. A redirect empties both buffers and abandons any request still outstanding. It then fetches the aligned line that holds the new target and starts the read point at the target's offset within that line. Each request carries a sequence tag. A response whose tag belongs to an earlier redirect is dropped.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the window count is 0, and a line request for address 0 is offered.
- R2: At most one line request is outstanding. While one is outstanding, `req_valid` stays low.
- R3: Every request address is aligned to 16 bytes. Successive requests after a redirect ask for consecutive lines: aligned target, then +16, then +32, and so on.
- R4: `win_count` equals the number of valid bytes from the read point onward, capped at 8. It is 0 when the current buffer is empty.
- R5: Byte i of the window sits at `win_bytes[8*i+7:8*i]` and holds the instruction byte at address read-point + i. This still holds when the window crosses from one buffer into the other.
- R6: A consume of c bytes with c ≤ `win_count` advances the read point by c on the next clock edge. A consume with c > `win_count` is ignored, and the window is left unchanged.
- R7: In the cycle after the last byte of a buffer is consumed, and if no request is outstanding, a request is offered for the next sequential line.
- R8: A redirect to address A empties the window on the next edge and clears any outstanding request. It then requests line A with its low 4 bits cleared, and the first window byte shown afterwards is the byte at A. A redirect takes priority over a consume in the same cycle.
- R9: A response is accepted only if `rsp_tag` equals the tag of the request now outstanding. A response issued for a request made before the latest redirect is dropped, and its data never reaches the window.
- R10: While both buffers hold valid lines, no request is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_valid | input | 1 | Flush and restart at `redirect_addr` |
| redirect_addr | input | AW | New fetch byte address |
| req_valid | output | 1 | Line request offered |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | AW | 16-byte-aligned line address |
| req_tag | output | TAGW | Sequence tag of the request |
| rsp_valid | input | 1 | Line response present |
| rsp_tag | input | TAGW | Tag echoed with the response |
| rsp_data | input | 8*LINE | Line data, byte j in bits [8j+7:8j] |
| win_bytes | output | 8*WIN | Next bytes from the read point |
| win_count | output | CW | Valid bytes in the window (0..8) |
| consume | input | CW | Bytes taken by the decoder this cycle |

## Verification
The window and the request signals are combinational from registered state. A consume, a response or a redirect presented before an edge therefore shows up on `win_bytes`, `win_count` and `req_valid` straight after that edge, in the same cycle, with no extra register in the way. The bench changes inputs on the falling edge and samples outputs on the falling edge that follows. Each check therefore sees the result of exactly one rising edge. The bench's memory model answers a fixed number of cycles after it accepts a request. The directed checks are placed inside the gap before a second line can land, which keeps the partial-window counts stable while they are read.

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int AW   = 32,
  parameter int LINE = 16,
  parameter int WIN  = 8,
  parameter int TAGW = 2,
  localparam int OFFW = $clog2(LINE),
  localparam int CW   = $clog2(WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect_valid,
  input  logic [AW-1:0]     redirect_addr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  output logic [TAGW-1:0]   req_tag,
  input  logic              rsp_valid,
  input  logic [TAGW-1:0]   rsp_tag,
  input  logic [8*LINE-1:0] rsp_data,
  output logic [8*WIN-1:0]  win_bytes,
  output logic [CW-1:0]     win_count,
  input  logic [CW-1:0]     consume
);

  logic [8*LINE-1:0] line_q [2];
  logic [1:0]        vld_q;
  logic              hd_q;
  logic [OFFW-1:0]   off_q;
  logic              pend_q;
  logic [TAGW-1:0]   seq_q;
  logic [AW-1:0]     nxt_q;

  logic              tgt;
  logic              take_req, take_rsp, cons_ok;
  logic [OFFW+1:0]   avail;
  logic [OFFW:0]     sum;

  assign tgt       = vld_q[hd_q] ? ~hd_q : hd_q;
  assign req_valid = !pend_q && !(&vld_q);
  assign req_addr  = nxt_q;
  assign req_tag   = seq_q;
  assign take_req  = req_valid && req_ready && !redirect_valid;
  assign take_rsp  = rsp_valid && pend_q && (rsp_tag == seq_q) && !redirect_valid;

  always_comb begin
    avail = '0;
    if (vld_q[hd_q])
      avail = (OFFW+2)'(LINE) - (OFFW+2)'(off_q)
            + (vld_q[~hd_q] ? (OFFW+2)'(LINE) : '0);
  end

  assign win_count = (avail > (OFFW+2)'(WIN)) ? CW'(WIN) : avail[CW-1:0];
  assign cons_ok   = (consume != '0) && (consume <= win_count) && !redirect_valid;
  assign sum       = {1'b0, off_q} + (OFFW+1)'(consume);

  for (genvar i = 0; i < WIN; i++) begin : g_win
    logic [OFFW:0] p;
    assign p = {1'b0, off_q} + (OFFW+1)'(i);
    assign win_bytes[8*i +: 8] = line_q[hd_q ^ p[OFFW]][8*p[OFFW-1:0] +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      hd_q   <= 1'b0;
      off_q  <= '0;
      pend_q <= 1'b0;
      seq_q  <= '0;
      nxt_q  <= '0;
    end else if (redirect_valid) begin
      vld_q  <= '0;
      off_q  <= redirect_addr[OFFW-1:0];
      nxt_q  <= {redirect_addr[AW-1:OFFW], {OFFW{1'b0}}};
      pend_q <= 1'b0;
      seq_q  <= seq_q + 1'b1;
    end else begin
      if (take_req) pend_q <= 1'b1;
      if (take_rsp) begin
        pend_q      <= 1'b0;
        line_q[tgt] <= rsp_data;
        vld_q[tgt]  <= 1'b1;
        nxt_q       <= nxt_q + AW'(LINE);
      end
      if (cons_ok) begin
        off_q <= sum[OFFW-1:0];
        if (sum[OFFW]) begin
          vld_q[hd_q] <= 1'b0;
          hd_q        <= ~hd_q;
        end
      end
    end
  end

  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !req_valid);

  a_r10_full_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (&vld_q) |-> !req_valid);

  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[OFFW-1:0] == '0));

  a_r4_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    win_count <= CW'(WIN));

  a_r6_overconsume_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (consume > win_count && !redirect_valid) |=> ($stable(off_q) && $stable(hd_q)));

  a_r8_redirect_flush: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (win_count == '0 && !pend_q));

endmodule

// File: tb/sim_prefetch_queue.sv
module sim_prefetch_queue;
  localparam int PERIOD = 10;
  localparam int LAT    = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         redirect_valid;
  logic [31:0]  redirect_addr;
  logic         req_valid, req_ready;
  logic [31:0]  req_addr;
  logic [1:0]   req_tag;
  logic         rsp_valid;
  logic [1:0]   rsp_tag;
  logic [127:0] rsp_data;
  logic [63:0]  win_bytes;
  logic [3:0]   win_count;
  logic [3:0]   consume;

  prefetch_queue u0 (
    .clk(clk), .rst_n(rst_n),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .win_bytes(win_bytes), .win_count(win_count), .consume(consume)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [7:0] fb(input logic [31:0] a);
    return (a[7:0] * 8'd5) ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [127:0] fl(input logic [31:0] a);
    logic [127:0] r;
    for (int j = 0; j < 16; j++) r[8*j +: 8] = fb(a + 32'(j));
    return r;
  endfunction

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  logic        hold;
  logic        busy;
  logic [2:0]  cnt;
  logic [31:0] caddr;
  logic [1:0]  ctag;
  assign req_ready = !busy && !hold;

  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (!rst_n) busy <= 1'b0;
    else if (busy) begin
      if (cnt == 0) begin
        rsp_valid <= 1'b1;
        rsp_tag   <= ctag;
        rsp_data  <= fl(caddr);
        busy      <= 1'b0;
      end else cnt <= cnt - 1'b1;
    end else if (req_valid && !hold) begin
      busy  <= 1'b1;
      caddr <= req_addr;
      ctag  <= req_tag;
      cnt   <= 3'(LAT);
    end
  end

  initial begin
    #(PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic redir(input logic [31:0] a);
    @(negedge clk);
    redirect_valid = 1'b1;
    redirect_addr  = a;
    consume        = '0;
    @(negedge clk);
    redirect_valid = 1'b0;
  endtask

  task automatic wait_nonzero();
    for (int g = 0; g < 40; g++) begin
      if (win_count != 0) break;
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; redirect_valid = 1'b0; redirect_addr = '0; consume = '0; hold = 1'b1;
    rsp_tag = '0; rsp_data = '0; busy = 1'b0; cnt = '0; caddr = '0; ctag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(win_count == 0, "R1 count", 64'(win_count), 0);
    chk(req_valid == 1'b1, "R1 req_valid", 64'(req_valid), 1);
    chk(req_addr == 0, "R1 req_addr", 64'(req_addr), 0);

    // R8 skip to offset 11 of line 0x1230
    redir(32'h123B);
    chk(win_count == 0, "R8 flushed", 64'(win_count), 0);
    chk(req_addr == 32'h1230, "R3 aligned", 64'(req_addr), 64'h1230);
    hold = 1'b0;
    wait_nonzero();
    chk(win_count == 5, "R4 partial count", 64'(win_count), 5);
    chk(win_bytes[7:0] == fb(32'h123B), "R8 first byte", 64'(win_bytes[7:0]), 64'(fb(32'h123B)));
    consume = 4'd6;
    @(negedge clk);
    consume = '0;
    chk(win_count == 5, "R6 overconsume count", 64'(win_count), 5);
    chk(win_bytes[7:0] == fb(32'h123B), "R6 overconsume byte", 64'(win_bytes[7:0]), 64'(fb(32'h123B)));
    repeat (12) @(negedge clk);
    chk(win_count == 8, "R4 full count", 64'(win_count), 8);
    for (int i = 0; i < 8; i++)
      chk(win_bytes[8*i +: 8] == fb(32'h123B + 32'(i)), "R5 straddle byte",
          64'(win_bytes[8*i +: 8]), 64'(fb(32'h123B + 32'(i))));
    chk(req_valid == 1'b0, "R10 both full", 64'(req_valid), 0);
    hold = 1'b1;
    consume = 4'd5;
    @(negedge clk);
    consume = '0;
    chk(req_valid == 1'b1, "R7 refill offered", 64'(req_valid), 1);
    chk(req_addr == 32'h1250, "R3 sequential", 64'(req_addr), 64'h1250);
    chk(win_bytes[7:0] == fb(32'h1240), "R6 advance", 64'(win_bytes[7:0]), 64'(fb(32'h1240)));

    // R9 stale response after a second redirect
    redir(32'h3000);
    hold = 1'b0;
    @(negedge clk);
    chk(req_valid == 1'b0, "R2 one outstanding", 64'(req_valid), 0);
    redir(32'h2005);
    repeat (20) @(negedge clk);
    chk(win_bytes[7:0] == fb(32'h2005), "R9 stale dropped", 64'(win_bytes[7:0]), 64'(fb(32'h2005)));
    chk(win_count == 8, "R9 refilled", 64'(win_count), 8);

    // Sweep every start offset and consume size
    for (int t = 0; t < 16; t++) begin
      for (int k = 1; k <= 8; k++) begin
        logic [31:0] pc;
        int n;
        pc = 32'h100 + 32'(t) + 32'(k * 32'h40);
        redir(pc);
        n = 0;
        for (int g = 0; g < 400 && n < 40; g++) begin
          chk(win_count <= 8, "R4 cap", 64'(win_count), 8);
          for (int i = 0; i < 8; i++)
            if (i < int'(win_count))
              chk(win_bytes[8*i +: 8] == fb(pc + 32'(i)), "R5 stream byte",
                  64'(win_bytes[8*i +: 8]), 64'(fb(pc + 32'(i))));
          if (int'(win_count) >= k) begin
            consume = 4'(k);
            pc = pc + 32'(k);
            n = n + k;
          end else consume = '0;
          @(negedge clk);
        end
        consume = '0;
        chk(n >= 40, "R6 stream progress", 64'(n), 40);
      end
    end
    summary();
  end
endmodule